// File: doc/BRIEF.md
# NAND Flash Write-Cycle Sequencer

This block turns host requests into the write-side bus cycles of an 8-bit multiplexed asynchronous NAND flash port, running from a synchronous controller clock. One request carries a command byte, an address byte, or a data burst with a byte count. The block drives the chip select, the command latch, the address latch and the write strobe. It drives the shared I/O bus with an output enable, and it stretches every phase until all minimum timing limits hold. Each limit is an input given in clock cycles, already rounded up from nanoseconds at the clock period.

The request handshake is valid/ready. Data bytes are pulled from a side stream: `dat_take` pulses in the cycle in which `dat_byte` is latched. Chip select stays asserted from one request to the next, so a command followed by several address bytes forms one chip-enable window. It is released only after a request that had `req_end` set. `done` pulses once after the hold phase of the final strobe of each request has finished.

The controller has four states. ST_IDLE moves to ST_SETUP when a request is accepted. ST_SETUP moves to ST_STROBE when every setup limit is met. ST_STROBE moves to ST_HOLD when the low-time count is reached. When the hold count is reached, ST_HOLD moves back to ST_SETUP if burst bytes remain, and otherwise to ST_IDLE.

Top module: `nand_wr_seq`

## Requirements
- R1: After reset, chip select and write strobe are high (inactive), both latch lines are low, the output enable is low, `req_ready` is 1 and `done` is 0.
- R2: `req_kind` 2'b00 is a command (command latch high, address latch low). 2'b01 is an address (address latch high, command latch low). 2'b10 and 2'b11 are data (both latches low). The byte on the bus at each rising strobe is `req_byte` for a command or address, and the next stream byte for data.
- R3: Each write strobe stays low for exactly max(cfg_wp,1) cycles.
- R4: Any change of the latch lines or of the bus value occurs at least max(cfg_setup, max(cfg_wp,1)+1) cycles before the next rising strobe.
- R5: Chip select falls at least cfg_cs cycles before the next rising strobe.
- R6: The strobe stays high for at least cfg_wh cycles between pulses, and successive rising strobes are at least cfg_wc cycles apart.
- R7: No latch line, bus value, output enable or chip select changes within max(cfg_hold,1) cycles after a rising strobe.
- R8: When a data strobe follows an address strobe, the two rising edges are at least cfg_adl cycles apart.
- R9: Latch lines, bus value and chip select never change while the strobe is low.
- R10: A data burst strobes max(1, min(req_len, 2112)) bytes. `dat_take` pulses once per byte, only while the strobe is high, and bytes leave in stream order.
- R11: Chip select stays low after a request without `req_end`. It goes high in the same cycle as `done` for a request with `req_end`.
- R12: `req_ready` is high only in idle. `done` is a single-cycle pulse per request. From an idle start after reset, `done` appears 1+P+L+H cycles after acceptance, where L=max(cfg_wp,1), H=max(cfg_hold,1) and P=max(1, cfg_setup-L, cfg_cs-L).
- R13: The output enable is high only while chip select is low, and it is high during every strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_setup | input | CW | Latch/data setup before rising strobe, cycles |
| cfg_cs | input | CW | Chip select fall to rising strobe, cycles |
| cfg_wp | input | CW | Strobe low width, cycles |
| cfg_wh | input | CW | Strobe high width, cycles |
| cfg_wc | input | CW | Rising-to-rising strobe period, cycles |
| cfg_hold | input | CW | Hold after rising strobe, cycles |
| cfg_adl | input | CW | Last address to first data strobe gap, cycles |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with valid |
| req_kind | input | 2 | Request type (see R2) |
| req_byte | input | 8 | Command or address byte |
| req_len | input | LW | Data burst byte count |
| req_end | input | 1 | Release chip select after this request |
| dat_byte | input | 8 | Data stream byte |
| dat_take | output | 1 | Stream byte latched this cycle |
| done | output | 1 | Request finished pulse |
| fl_sel_n | output | 1 | Chip select, active low |
| fl_cmd_lat | output | 1 | Command latch enable |
| fl_adr_lat | output | 1 | Address latch enable |
| fl_wstb_n | output | 1 | Write strobe, active low |
| fl_dq_o | output | 8 | I/O bus output value |
| fl_dq_oe | output | 1 | I/O bus output enable |

## Verification
Suppose a phase counter starts in the wrong place or the controller leaves a state at the wrong time. The pins then show it at the next rising strobe, as a low pulse of the wrong width, a setup or cycle-period shortfall, or a byte of the wrong type or value. A stuck burst counter shows up within one request, as a surplus or missing data strobe and a `done` count that differs from the number of requests. A wrong chip-select or output-enable flag shows up at the first `done` or strobe after it goes wrong.

// File: rtl/nws_pkg.sv
package nws_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD
    } nws_state_e;

    localparam logic [1:0] KIND_CMD = 2'b00;
    localparam logic [1:0] KIND_ADR = 2'b01;
endpackage

// File: rtl/nws_satcnt.sv
module nws_satcnt #(
    parameter int W        = 8,
    parameter bit RST_ONES = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    output logic [W-1:0] q
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= RST_ONES ? '1 : '0;
        else if (clr)
            q <= '0;
        else if (q != '1)
            q <= q + ONE;
    end
endmodule

// File: rtl/nws_gate.sv
module nws_gate #(
    parameter int CW = 8
) (
    input  logic [CW-1:0] pre_cnt,
    input  logic [CW-1:0] ce_cnt,
    input  logic [CW-1:0] hi_cnt,
    input  logic [CW-1:0] lo_len,
    input  logic [CW-1:0] cfg_setup,
    input  logic [CW-1:0] cfg_cs,
    input  logic [CW-1:0] cfg_wh,
    input  logic [CW-1:0] cfg_wc,
    input  logic [CW-1:0] cfg_adl,
    input  logic          need_adl,
    output logic          go
);
    localparam int SW = CW + 2;
    localparam logic [SW-1:0] ONE_S = {{(SW-1){1'b0}}, 1'b1};

    logic [SW-1:0] e_pre, e_ce, e_hi, low_s;
    logic ok_setup, ok_cs, ok_wh, ok_wc, ok_adl;

    always_comb begin
        low_s    = {2'b00, lo_len};
        e_pre    = {2'b00, pre_cnt} + ONE_S;
        e_ce     = {2'b00, ce_cnt} + ONE_S;
        e_hi     = {2'b00, hi_cnt} + ONE_S;
        ok_setup = (e_pre + low_s) >= {2'b00, cfg_setup};
        ok_cs    = (e_ce + low_s)  >= {2'b00, cfg_cs};
        ok_wh    = e_hi >= {2'b00, cfg_wh};
        ok_wc    = (e_hi + low_s)  >= {2'b00, cfg_wc};
        ok_adl   = !need_adl || ((e_hi + low_s) >= {2'b00, cfg_adl});
        go       = ok_setup && ok_cs && ok_wh && ok_wc && ok_adl;
    end
endmodule

// File: rtl/nws_burst.sv
module nws_burst #(
    parameter int LW   = 12,
    parameter int PAGE = 2112
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          is_data,
    input  logic [LW-1:0] len,
    input  logic          step,
    output logic          more
);
    localparam logic [LW-1:0] PAGE_L = LW'(PAGE);
    localparam logic [LW-1:0] ONE_L  = {{(LW-1){1'b0}}, 1'b1};

    logic [LW-1:0] eff, rem_q;

    always_comb begin
        if (len == '0)
            eff = ONE_L;
        else if (len > PAGE_L)
            eff = PAGE_L;
        else
            eff = len;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rem_q <= '0;
        else if (load)
            rem_q <= is_data ? (eff - ONE_L) : '0;
        else if (step && rem_q != '0)
            rem_q <= rem_q - ONE_L;
    end

    assign more = (rem_q != '0);
endmodule

// File: rtl/nand_wr_seq.sv
module nand_wr_seq
    import nws_pkg::*;
#(
    parameter int CW   = 8,
    parameter int LW   = 12,
    parameter int PAGE = 2112
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cfg_setup,
    input  logic [CW-1:0] cfg_cs,
    input  logic [CW-1:0] cfg_wp,
    input  logic [CW-1:0] cfg_wh,
    input  logic [CW-1:0] cfg_wc,
    input  logic [CW-1:0] cfg_hold,
    input  logic [CW-1:0] cfg_adl,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [1:0]    req_kind,
    input  logic [7:0]    req_byte,
    input  logic [LW-1:0] req_len,
    input  logic          req_end,
    input  logic [7:0]    dat_byte,
    output logic          dat_take,
    output logic          done,
    output logic          fl_sel_n,
    output logic          fl_cmd_lat,
    output logic          fl_adr_lat,
    output logic          fl_wstb_n,
    output logic [7:0]    fl_dq_o,
    output logic          fl_dq_oe
);
    localparam logic [CW-1:0] ONE_C = {{(CW-1){1'b0}}, 1'b1};
    localparam logic [CW:0]   ONE_X = {{CW{1'b0}}, 1'b1};

    nws_state_e    st_q, st_d;
    logic [CW-1:0] ph_cnt, ce_cnt, hi_cnt, lo_len, hd_len;
    logic          go, more, accept, lo_end, hd_end, hold_fin;
    logic          cmd_q, adr_q, data_q, ce_open_q, end_q, adl_q, done_q;
    logic [7:0]    dq_q;

    assign lo_len   = (cfg_wp == '0)   ? ONE_C : cfg_wp;
    assign hd_len   = (cfg_hold == '0) ? ONE_C : cfg_hold;
    assign accept   = (st_q == ST_IDLE) && req_valid;
    assign lo_end   = ({1'b0, ph_cnt} + ONE_X) >= {1'b0, lo_len};
    assign hd_end   = ({1'b0, ph_cnt} + ONE_X) >= {1'b0, hd_len};
    assign hold_fin = (st_q == ST_HOLD) && hd_end;

    // Phase counter restarts on each state change.
    nws_satcnt #(.W(CW), .RST_ONES(1'b0)) u_phase (
        .clk(clk), .rst_n(rst_n), .clr(st_d != st_q), .q(ph_cnt)
    );
    // Cycles the strobe has been high; saturated at reset so idle never blocks.
    nws_satcnt #(.W(CW), .RST_ONES(1'b1)) u_high (
        .clk(clk), .rst_n(rst_n), .clr(st_q == ST_STROBE), .q(hi_cnt)
    );
    // Cycles since chip select was asserted.
    nws_satcnt #(.W(CW), .RST_ONES(1'b0)) u_sel (
        .clk(clk), .rst_n(rst_n), .clr(!ce_open_q), .q(ce_cnt)
    );

    nws_gate #(.CW(CW)) u_gate (
        .pre_cnt  (ph_cnt),
        .ce_cnt   (ce_cnt),
        .hi_cnt   (hi_cnt),
        .lo_len   (lo_len),
        .cfg_setup(cfg_setup),
        .cfg_cs   (cfg_cs),
        .cfg_wh   (cfg_wh),
        .cfg_wc   (cfg_wc),
        .cfg_adl  (cfg_adl),
        .need_adl (adl_q && data_q),
        .go       (go)
    );

    nws_burst #(.LW(LW), .PAGE(PAGE)) u_burst (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (accept),
        .is_data(req_kind[1]),
        .len    (req_len),
        .step   (hold_fin && more),
        .more   (more)
    );

    // Next-state logic.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:   if (req_valid) st_d = ST_SETUP;
            ST_SETUP:  if (go)        st_d = ST_STROBE;
            ST_STROBE: if (lo_end)    st_d = ST_HOLD;
            ST_HOLD:   if (hd_end)    st_d = more ? ST_SETUP : ST_IDLE;
            default:                  st_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= ST_IDLE;
        else
            st_q <= st_d;
    end

    // Cycle attributes; they change only on entry to setup or on leaving hold.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q     <= 1'b0;
            adr_q     <= 1'b0;
            data_q    <= 1'b0;
            ce_open_q <= 1'b0;
            end_q     <= 1'b0;
            adl_q     <= 1'b0;
            done_q    <= 1'b0;
            dq_q      <= '0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                cmd_q     <= (req_kind == KIND_CMD);
                adr_q     <= (req_kind == KIND_ADR);
                data_q    <= req_kind[1];
                dq_q      <= req_kind[1] ? dat_byte : req_byte;
                ce_open_q <= 1'b1;
                end_q     <= req_end;
            end else if (hold_fin) begin
                adl_q <= adr_q;
                if (more) begin
                    dq_q <= dat_byte;
                end else begin
                    cmd_q  <= 1'b0;
                    adr_q  <= 1'b0;
                    done_q <= 1'b1;
                    if (end_q)
                        ce_open_q <= 1'b0;
                end
            end
        end
    end

    // Outputs.
    always_comb begin
        req_ready  = (st_q == ST_IDLE);
        fl_wstb_n  = (st_q != ST_STROBE);
        fl_dq_oe   = (st_q != ST_IDLE);
        fl_sel_n   = !ce_open_q;
        fl_cmd_lat = cmd_q;
        fl_adr_lat = adr_q;
        fl_dq_o    = dq_q;
        done       = done_q;
        dat_take   = (accept && req_kind[1]) || (hold_fin && more);
    end
endmodule

// File: rtl/nand_wr_seq_chk.sv
module nand_wr_seq_chk #(
    parameter int CW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [CW-1:0] cfg_wp,
    input logic          req_ready,
    input logic          dat_take,
    input logic          done,
    input logic          fl_sel_n,
    input logic          fl_cmd_lat,
    input logic          fl_adr_lat,
    input logic          fl_wstb_n,
    input logic [7:0]    fl_dq_o,
    input logic          fl_dq_oe
);
    logic          armed, prev_we;
    logic [CW:0]   lowc;
    logic [CW:0]   want_low;

    assign want_low = (cfg_wp == '0) ? {{CW{1'b0}}, 1'b1} : {1'b0, cfg_wp};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed   <= 1'b0;
            prev_we <= 1'b1;
            lowc    <= '0;
        end else begin
            armed   <= 1'b1;
            prev_we <= fl_wstb_n;
            lowc    <= fl_wstb_n ? '0 : (lowc + {{CW{1'b0}}, 1'b1});
            if (fl_wstb_n && !prev_we)
                AST_LOW_WIDTH: assert (lowc == want_low)
                    else $error("strobe low width %0d", lowc); // R3
        end
    end

    AST_STABLE_WHILE_LOW: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        (!fl_wstb_n && $past(!fl_wstb_n)) |-> ($stable(fl_cmd_lat) && $stable(fl_adr_lat) && $stable(fl_dq_o) && $stable(fl_sel_n))); // R9
    AST_ONE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        !(fl_cmd_lat && fl_adr_lat)); // R2
    AST_OE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        fl_dq_oe |-> !fl_sel_n); // R13
    AST_STROBE_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_wstb_n |-> (fl_dq_oe && !fl_sel_n)); // R13
    AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (fl_wstb_n && !fl_dq_oe)); // R12
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R12
    AST_TAKE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        dat_take |-> fl_wstb_n); // R10
endmodule

bind nand_wr_seq nand_wr_seq_chk #(.CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wp    (cfg_wp),
    .req_ready (req_ready),
    .dat_take  (dat_take),
    .done      (done),
    .fl_sel_n  (fl_sel_n),
    .fl_cmd_lat(fl_cmd_lat),
    .fl_adr_lat(fl_adr_lat),
    .fl_wstb_n (fl_wstb_n),
    .fl_dq_o   (fl_dq_o),
    .fl_dq_oe  (fl_dq_oe)
);

// File: tb/nand_wr_seq_tb.sv
`timescale 1ns/1ps
module nand_wr_seq_tb_top;
    localparam int CW = 8, LW = 12, PAGE = 2112;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [CW-1:0] cfg_setup, cfg_cs, cfg_wp, cfg_wh, cfg_wc, cfg_hold, cfg_adl;
    logic req_valid = 0, req_end = 0;
    logic [1:0] req_kind = 0;
    logic [7:0] req_byte = 0;
    logic [LW-1:0] req_len = 0;
    logic [7:0] dat_byte;
    logic req_ready, dat_take, done, fl_sel_n, fl_cmd_lat, fl_adr_lat, fl_wstb_n, fl_dq_oe;
    logic [7:0] fl_dq_o;

    always #2 clk = ~clk;

    nand_wr_seq #(.CW(CW), .LW(LW), .PAGE(PAGE)) dut_i (.*);

    int n_chk = 0, n_bad = 0, n_req = 0, n_done = 0, n_drise = 0;
    int didx = 0, dseen = 0, cyc = 0;
    int exp_k[$], exp_b[$];
    bit finished = 0;

    function automatic logic [7:0] f_dat(input int k);
        return 8'((k * 37 + 11) ^ (k >> 8));
    endfunction
    function automatic int f_lo(input int v);
        return (v == 0) ? 1 : v;
    endfunction
    function automatic int f_clamp(input int len);
        if (len == 0) return 1;
        if (len > PAGE) return PAGE;
        return len;
    endfunction
    function automatic int f_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    assign dat_byte = f_dat(didx);
    always @(posedge clk) if (dat_take) didx <= didx + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Pin monitor
    logic p_we = 1, p_cle = 0, p_ale = 0, p_ce = 1, p_oe = 0;
    logic [7:0] p_io = 0;
    int chg_cyc = -1000, ce_fall = -1000, fall_cyc = -1000, rise_cyc = -1000;
    bit have_rise = 0, prev_addr = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            bit changed;
            cyc++;
            changed = (fl_cmd_lat != p_cle) || (fl_adr_lat != p_ale) || (fl_dq_oe != p_oe) ||
                      (fl_dq_oe && fl_dq_o != p_io);
            if (changed) chg_cyc = cyc;
            if (!fl_wstb_n && !p_we)
                chk(!changed && fl_sel_n == p_ce, "R9 change while strobe low", int'(changed), 0);
            if (have_rise && (changed || fl_sel_n != p_ce))
                chk(cyc - rise_cyc >= f_lo(cfg_hold), "R7 hold after rise", cyc - rise_cyc, f_lo(cfg_hold));
            if (!fl_sel_n && p_ce) ce_fall = cyc;
            if (fl_dq_oe) chk(!fl_sel_n, "R13 enable outside select", int'(fl_sel_n), 0);
            if (!fl_wstb_n && p_we) begin
                if (have_rise) chk(cyc - rise_cyc >= cfg_wh, "R6 high time", cyc - rise_cyc, cfg_wh);
                chk(fl_dq_oe, "R13 enable at strobe", int'(fl_dq_oe), 1);
                fall_cyc = cyc;
            end
            if (fl_wstb_n && !p_we) begin
                int k;
                k = fl_cmd_lat ? 0 : (fl_adr_lat ? 1 : 2);
                chk(cyc - fall_cyc == f_lo(cfg_wp), "R3 low width", cyc - fall_cyc, f_lo(cfg_wp));
                chk(cyc - chg_cyc >= f_max(cfg_setup, f_lo(cfg_wp) + 1), "R4 setup",
                    cyc - chg_cyc, f_max(cfg_setup, f_lo(cfg_wp) + 1));
                chk(cyc - ce_fall >= cfg_cs, "R5 select setup", cyc - ce_fall, cfg_cs);
                if (have_rise) chk(cyc - rise_cyc >= cfg_wc, "R6 cycle time", cyc - rise_cyc, cfg_wc);
                if (have_rise && prev_addr && k == 2)
                    chk(cyc - rise_cyc >= cfg_adl, "R8 address to data", cyc - rise_cyc, cfg_adl);
                if (exp_k.size() == 0) begin
                    chk(0, "R2 unexpected strobe", k, -1);
                end else begin
                    int ek, eb;
                    ek = exp_k.pop_front();
                    eb = exp_b.pop_front();
                    if (ek == 2) begin
                        eb = f_dat(dseen);
                        dseen++;
                    end
                    chk(k == ek, "R2 cycle type", k, ek);
                    chk(fl_dq_o == 8'(eb), (k == 2) ? "R10 data order" : "R2 byte value", fl_dq_o, eb);
                end
                if (k == 2) n_drise++;
                prev_addr = (k == 1);
                rise_cyc  = cyc;
                have_rise = 1;
            end
            if (done) begin
                n_done++;
                chk(req_ready && fl_wstb_n, "R12 done in idle", int'(req_ready), 1);
            end
            p_we = fl_wstb_n; p_cle = fl_cmd_lat; p_ale = fl_adr_lat;
            p_ce = fl_sel_n;  p_oe = fl_dq_oe;    p_io = fl_dq_o;
        end
    end

    task automatic push_exp(input logic [1:0] k, input logic [7:0] b, input int len);
        int n;
        n = k[1] ? f_clamp(len) : 1;
        for (int i = 0; i < n; i++) begin
            exp_k.push_back(k[1] ? 2 : int'(k));
            exp_b.push_back(int'(b));
        end
        n_req++;
    endtask

    task automatic issue(input logic [1:0] k, input logic [7:0] b, input int len, input bit e);
        @(negedge clk);
        req_valid = 1; req_kind = k; req_byte = b; req_len = LW'(len); req_end = e;
        push_exp(k, b, len);
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic wait_idle();
        while (exp_k.size() != 0 || !req_ready) @(negedge clk);
        repeat (6) @(negedge clk);
    endtask

    task automatic set_cfg(input int s, input int c, input int p, input int h, input int w, input int d, input int a);
        cfg_setup = CW'(s); cfg_cs = CW'(c); cfg_wp = CW'(p); cfg_wh = CW'(h);
        cfg_wc = CW'(w); cfg_hold = CW'(d); cfg_adl = CW'(a);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        summary();
    end

    initial begin
        int n, p, l, h, d0;
        void'($urandom(32'h5EED_0042));
        set_cfg(3, 5, 3, 3, 7, 2, 25);
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(fl_sel_n && fl_wstb_n && !fl_cmd_lat && !fl_adr_lat && !fl_dq_oe && req_ready && !done,
            "R1 reset state", {fl_sel_n, fl_wstb_n, fl_cmd_lat, fl_adr_lat, fl_dq_oe, req_ready, done}, 7'b1100010);
        rst_n = 1;
        @(negedge clk);
        chk(fl_sel_n && fl_wstb_n && req_ready && !fl_dq_oe, "R1 after release",
            {fl_sel_n, fl_wstb_n, req_ready, fl_dq_oe}, 4'b1110);

        // R12 exact latency from idle
        l = f_lo(3); h = f_lo(2); p = f_max(1, f_max(3 - l, 5 - l));
        req_valid = 1; req_kind = 2'b00; req_byte = 8'h70; req_len = 0; req_end = 0;
        push_exp(2'b00, 8'h70, 0);
        @(negedge clk);
        req_valid = 0;
        n = 1;
        while (!done && n < 1000) begin @(negedge clk); n++; end
        chk(n == 1 + p + l + h, "R12 latency", n, 1 + p + l + h);
        wait_idle();

        // R11 select kept open without end, released with end
        chk(!fl_sel_n, "R11 select held open", fl_sel_n, 0);
        issue(2'b01, 8'hA5, 0, 1);
        while (!done) @(negedge clk);
        chk(fl_sel_n, "R11 select released at done", fl_sel_n, 1);
        wait_idle();

        // R8 address then data, R10 zero length gives one byte
        issue(2'b00, 8'h80, 0, 0);
        issue(2'b01, 8'h12, 0, 0);
        issue(2'b01, 8'h34, 0, 0);
        d0 = n_drise;
        issue(2'b10, 8'h00, 4, 0);
        wait_idle();
        chk(n_drise - d0 == 4, "R10 burst of four", n_drise - d0, 4);
        d0 = n_drise;
        issue(2'b11, 8'h00, 0, 1);
        wait_idle();
        chk(n_drise - d0 == 1, "R10 zero length", n_drise - d0, 1);

        // R10 clamp to one page
        set_cfg(1, 1, 1, 1, 1, 1, 1);
        d0 = n_drise;
        issue(2'b10, 8'h00, 3000, 1);
        wait_idle();
        chk(n_drise - d0 == PAGE, "R10 page clamp", n_drise - d0, PAGE);

        // Random mix
        for (int i = 0; i < 80; i++) begin
            if (i % 10 == 0) begin
                wait_idle();
                set_cfg($urandom_range(0, 5), $urandom_range(0, 8), $urandom_range(0, 4),
                        $urandom_range(0, 4), $urandom_range(0, 10), $urandom_range(0, 3),
                        $urandom_range(0, 30));
            end
            issue(2'($urandom_range(0, 3)), 8'($urandom), $urandom_range(0, 8),
                  ($urandom_range(0, 3) == 0));
        end
        wait_idle();
        chk(exp_k.size() == 0, "R2 all strobes seen", exp_k.size(), 0);
        chk(n_done == n_req, "R12 one done per request", n_done, n_req);
        summary();
    end
endmodule